// File: doc/BRIEF.md
# Masked Packed Double-to-Unsigned-Word Converter

This block takes a vector of up to eight IEEE-754 double-precision values and converts each one to a 32-bit unsigned integer. Every lane has its own scalar converter. A per-lane writemask decides which lanes take the converted value. An unselected lane either keeps the matching word of the previous destination (merging) or is cleared (zeroing). A "no writemask" input makes every active lane take its converted value.

The active width is 128, 256 or 512 source bits, which means 2, 4 or 8 lanes. The packed results fill the low half of a 512-bit destination, and everything above half the vector length is cleared. Two modes change how the lanes are fed:
- **Broadcast:** for a memory source, every lane converts the lowest 64-bit element.
- **Rounding override:** for a register source at full width, an embedded rounding mode replaces the global mode.

The invalid and inexact flags are ORed over the lanes that are actually written. The result, including the flags, is registered once, so it appears one clock after the inputs are applied.

Top module: `cvt_packed_u32`

## Requirements
- R1: Outputs are registered with one cycle of latency. An active-low asynchronous reset clears `dst_o`, `inv_o` and `inx_o` to zero.
- R2: The `vl_i` code sets the active lane count: 0 gives 2 lanes, 1 gives 4 lanes, and 2 or 3 give 8 lanes. Lanes at or above the count read zero and contribute no flags.
- R3: Bits 511:256 of `dst_o` are always zero.
- R4: Source lane j is `src_i[j*64+63:j*64]` and its result goes to `dst_o[j*32+31:j*32]`. An active lane is written with its converted value when `mask_i[j]` is 1 or `nomask_i` is 1.
- R5: An active lane that is not written takes `prev_i[j*32+31:j*32]` when `merge_i` is 1, and zero when `merge_i` is 0.
- R6: When `mem_src_i` and `bcst_i` are both 1, every lane converts `src_i[63:0]`. A register source with `bcst_i` set is not broadcast.
- R7: Rounding codes are 0 = to nearest even, 1 = toward minus infinity, 2 = toward plus infinity, 3 = toward zero. `emb_rm_i` replaces `glob_rm_i` only when `mem_src_i` is 0, `vl_i` is 2 or 3, and `bcst_i` is 1. In every other case `glob_rm_i` applies.
- R8: Each lane rounds its value to an integer under the selected mode. A result in 0..4294967295 is returned as that integer. A negative input that rounds to zero returns 0 and is valid. NaN, infinity, or a rounded result outside that range returns 32'hFFFFFFFF and is invalid.
- R9: A lane is inexact when rounding changed its value and the lane is not invalid. An invalid lane never reports inexact.
- R10: `inv_o` and `inx_o` are the OR of the per-lane flags over written lanes only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 512 | Packed double-precision source lanes |
| vl_i | input | 2 | Vector length code (0: 128, 1: 256, 2/3: 512) |
| bcst_i | input | 1 | Broadcast / embedded-rounding bit |
| mem_src_i | input | 1 | Source operand came from memory |
| mask_i | input | 8 | Per-lane writemask |
| nomask_i | input | 1 | Ignore the writemask, write all active lanes |
| merge_i | input | 1 | 1: merge unwritten lanes, 0: zero them |
| prev_i | input | 256 | Previous destination value |
| glob_rm_i | input | 2 | Global rounding mode |
| emb_rm_i | input | 2 | Embedded rounding mode |
| dst_o | output | 512 | Packed unsigned 32-bit results |
| inv_o | output | 1 | Invalid flag over written lanes |
| inx_o | output | 1 | Inexact flag over written lanes |

## Verification
The bench sweeps every mask under each width, merge setting and mask-bypass setting. A design that mixed up merging and zeroing, wrote lanes past the active count, or counted flags from masked-off lanes would return wrong words or flags there.

Quarter-step values from -3 to 10 and values just below and above 2^32 are run through all four rounding modes. These catch:
- wrong tie-to-even handling;
- negative fractions that round to zero wrongly reported as invalid;
- an overflow after rounding up that is not reported.

Every combination of memory flag, broadcast bit, width and both rounding inputs is applied with distinct lane contents. This shows whether broadcast leaks into register sources and whether the embedded mode is picked under the wrong conditions.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_DOWN = 2'd1,
        RM_UP   = 2'd2,
        RM_ZERO = 2'd3
    } rmode_e;

    localparam logic [1:0] VL_128 = 2'd0;
    localparam logic [1:0] VL_256 = 2'd1;

    localparam int F64_W   = 64;
    localparam int EXP_W   = 11;
    localparam int FRAC_W  = 52;
    localparam int U32_W   = 32;
    localparam int EXP_BIAS = 1023;
endpackage

// File: rtl/cvt_f64_u32.sv
module cvt_f64_u32
    import cvt_pkg::*;
(
    input  logic [F64_W-1:0] src_i,
    input  rmode_e           rm_i,
    output logic [U32_W-1:0] res_o,
    output logic             inv_o,
    output logic             inx_o
);
    localparam logic [EXP_W-1:0] EXP_MAX  = '1;
    localparam logic [EXP_W-1:0] EXP_BIG  = EXP_W'(EXP_BIAS + U32_W - 1);
    localparam logic [EXP_W-1:0] EXP_HALF = EXP_W'(EXP_BIAS - 1);
    localparam logic [EXP_W-1:0] EXP_SH0  = EXP_W'(EXP_BIAS + FRAC_W);

    logic               sgn;
    logic [EXP_W-1:0]   ex;
    logic [FRAC_W-1:0]  fr;
    logic [63:0]        mant, rem, half;
    logic [6:0]         sh;
    logic [U32_W:0]     intp, mag;
    logic               big, tiny, rbit, sbit, inc, bad;

    always_comb begin
        sgn  = src_i[F64_W-1];
        ex   = src_i[F64_W-2:FRAC_W];
        fr   = src_i[FRAC_W-1:0];
        mant = {{(64-FRAC_W-1){1'b0}}, 1'b1, fr};
        big  = (ex > EXP_BIG) || (ex == EXP_MAX);
        tiny = ex < EXP_HALF;
        sh   = tiny ? 7'd53 : 7'(EXP_SH0 - ex);
        half = 64'd1 << (sh - 7'd1);
        rem  = mant & ((64'd1 << sh) - 64'd1);
        if (tiny) begin
            intp = '0;
            rbit = 1'b0;
            sbit = |{ex, fr};
        end else begin
            intp = (U32_W+1)'(mant >> sh);
            rbit = |(rem & half);
            sbit = |(rem & (half - 64'd1));
        end
        unique case (rm_i)
            RM_NEAR: inc = rbit & (sbit | intp[0]);
            RM_DOWN: inc = sgn & (rbit | sbit);
            RM_UP:   inc = ~sgn & (rbit | sbit);
            default: inc = 1'b0;
        endcase
        mag   = intp + {{U32_W{1'b0}}, inc};
        bad   = big | mag[U32_W] | (sgn & (mag != '0));
        res_o = bad ? '1 : mag[U32_W-1:0];
        inv_o = bad;
        inx_o = ~bad & (rbit | sbit);
    end
endmodule

// File: rtl/cvt_lane_ctrl.sv
module cvt_lane_ctrl #(
    parameter int LANES = 8
) (
    input  logic [1:0]       vl_i,
    input  logic [LANES-1:0] mask_i,
    input  logic             nomask_i,
    output logic [LANES-1:0] act_o,
    output logic [LANES-1:0] wr_o
);
    localparam int CNT_W = $clog2(LANES + 1);

    logic [CNT_W-1:0] cnt;

    always_comb begin
        unique case (vl_i)
            cvt_pkg::VL_128: cnt = CNT_W'(LANES / 4);
            cvt_pkg::VL_256: cnt = CNT_W'(LANES / 2);
            default:         cnt = CNT_W'(LANES);
        endcase
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign act_o[j] = CNT_W'(j) < cnt;
        assign wr_o[j]  = act_o[j] & (nomask_i | mask_i[j]);
    end
endmodule

// File: rtl/cvt_packed_u32.sv
module cvt_packed_u32
    import cvt_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES*F64_W-1:0]   src_i,
    input  logic [1:0]               vl_i,
    input  logic                     bcst_i,
    input  logic                     mem_src_i,
    input  logic [LANES-1:0]         mask_i,
    input  logic                     nomask_i,
    input  logic                     merge_i,
    input  logic [LANES*U32_W-1:0]   prev_i,
    input  logic [1:0]               glob_rm_i,
    input  logic [1:0]               emb_rm_i,
    output logic [LANES*F64_W-1:0]   dst_o,
    output logic                     inv_o,
    output logic                     inx_o
);
    localparam int VEC_W = LANES * F64_W;

    typedef struct packed {
        logic [VEC_W-1:0] dst;
        logic             inv;
        logic             inx;
    } state_t;

    state_t state_d, state_q;

    logic [LANES-1:0]  act, wr, linv, linx;
    logic [U32_W-1:0]  lres [LANES];
    logic              splat, emb_sel;
    rmode_e            rm_eff;

    assign splat   = mem_src_i & bcst_i;
    assign emb_sel = ~mem_src_i & vl_i[1] & bcst_i;
    assign rm_eff  = rmode_e'(emb_sel ? emb_rm_i : glob_rm_i);

    cvt_lane_ctrl #(.LANES(LANES)) u_ctrl (
        .vl_i     (vl_i),
        .mask_i   (mask_i),
        .nomask_i (nomask_i),
        .act_o    (act),
        .wr_o     (wr)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [F64_W-1:0] lsrc;
        assign lsrc = splat ? src_i[F64_W-1:0] : src_i[j*F64_W +: F64_W];
        cvt_f64_u32 u_cvt (
            .src_i (lsrc),
            .rm_i  (rm_eff),
            .res_o (lres[j]),
            .inv_o (linv[j]),
            .inx_o (linx[j])
        );
    end

    always_comb begin
        state_d = '0;
        for (int j = 0; j < LANES; j++) begin
            if (wr[j])
                state_d.dst[j*U32_W +: U32_W] = lres[j];
            else if (act[j] && merge_i)
                state_d.dst[j*U32_W +: U32_W] = prev_i[j*U32_W +: U32_W];
        end
        state_d.inv = |(wr & linv);
        state_d.inx = |(wr & linx);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign dst_o = state_q.dst;
    assign inv_o = state_q.inv;
    assign inx_o = state_q.inx;
endmodule

// File: rtl/cvt_packed_u32_chk.sv
module cvt_packed_u32_chk (
    input logic         clk,
    input logic         rst_n,
    input logic [511:0] src_i,
    input logic [1:0]   vl_i,
    input logic         bcst_i,
    input logic         mem_src_i,
    input logic [7:0]   mask_i,
    input logic         nomask_i,
    input logic         merge_i,
    input logic [255:0] prev_i,
    input logic [1:0]   glob_rm_i,
    input logic [1:0]   emb_rm_i,
    input logic [511:0] dst_o,
    input logic         inv_o,
    input logic         inx_o
);
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        dst_o[511:256] == '0);

    a_r2_short_vector_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (vl_i == 2'd0) |=> (dst_o[255:64] == '0));

    a_r5_zeroing_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        (!nomask_i && !merge_i && !mask_i[0]) |=> (dst_o[31:0] == 32'd0));

    a_r5_merging_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        (!nomask_i && merge_i && !mask_i[0]) |=> (dst_o[31:0] == $past(prev_i[31:0])));

    a_r10_no_write_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (!nomask_i && mask_i == 8'd0) |=> (!inv_o && !inx_o));

    a_r9_invalid_lane_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (vl_i == 2'd0 && !mem_src_i && nomask_i && src_i[62:52] == 11'h7FF
         && src_i[126:116] == 11'h7FF) |=> (inv_o && !inx_o));
endmodule

bind cvt_packed_u32 cvt_packed_u32_chk u_chk (.*);

// File: tb/tb_cvt_packed_u32.sv
module tb_cvt_packed_u32;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [511:0] src_i = '0;
    logic [1:0]   vl_i = '0;
    logic         bcst_i = 1'b0;
    logic         mem_src_i = 1'b0;
    logic [7:0]   mask_i = '0;
    logic         nomask_i = 1'b0;
    logic         merge_i = 1'b0;
    logic [255:0] prev_i = '0;
    logic [1:0]   glob_rm_i = '0;
    logic [1:0]   emb_rm_i = '0;
    logic [511:0] dst_o;
    logic         inv_o, inx_o;

    int vectors = 0;
    int fails = 0;

    always #10 clk = ~clk;

    cvt_packed_u32 dut (.*);

    // {invalid, inexact, value} from real arithmetic
    function automatic logic [33:0] ref_cvt(input logic [63:0] b, input logic [1:0] rm);
        real x, fl, r, d;
        if (b[62:52] == 11'h7FF) return {2'b10, 32'hFFFFFFFF};
        x  = $bitstoreal(b);
        fl = $floor(x);
        case (rm)
            2'd0: begin
                d = x - fl;
                if (d > 0.5) r = fl + 1.0;
                else if (d < 0.5) r = fl;
                else r = ((fl / 2.0) == $floor(fl / 2.0)) ? fl : fl + 1.0;
            end
            2'd1: r = fl;
            2'd2: r = $ceil(x);
            default: r = (x < 0.0) ? $ceil(x) : fl;
        endcase
        if (r < 0.0 || r > 4294967295.0) return {2'b10, 32'hFFFFFFFF};
        return {1'b0, (r != x), 32'(longint'(r))};
    endfunction

    function automatic logic [63:0] pool(input int i);
        case (i % 16)
            0:  return $realtobits(0.0);
            1:  return $realtobits(1.5);
            2:  return $realtobits(2.5);
            3:  return 64'h8000_0000_0000_0000;
            4:  return $realtobits(-0.4);
            5:  return $realtobits(4294967295.0);
            6:  return $realtobits(4294967295.5);
            7:  return $realtobits(4294967296.0);
            8:  return 64'h7FF8_0000_0000_0000;
            9:  return 64'h7FF0_0000_0000_0000;
            10: return $realtobits(-1.0);
            11: return $realtobits(123456.75);
            12: return 64'h0000_0000_0000_0001;
            13: return $realtobits(0.5);
            14: return $realtobits(3.5);
            default: return $realtobits(1.0e20);
        endcase
    endfunction

    task automatic apply_check(input string tag);
        logic [511:0] edst;
        logic einv, einx;
        logic [33:0] r;
        logic [63:0] ls;
        logic [1:0] rm;
        int kl;
        @(negedge clk);
        @(negedge clk);
        kl = (vl_i == 2'd0) ? 2 : (vl_i == 2'd1) ? 4 : 8;
        rm = (!mem_src_i && vl_i[1] && bcst_i) ? emb_rm_i : glob_rm_i;   // R7
        edst = '0; einv = 1'b0; einx = 1'b0;
        for (int j = 0; j < 8; j++) begin
            if (j < kl) begin
                ls = (mem_src_i && bcst_i) ? src_i[63:0] : src_i[j*64 +: 64];
                if (nomask_i || mask_i[j]) begin
                    r = ref_cvt(ls, rm);
                    edst[j*32 +: 32] = r[31:0];
                    einv |= r[33];
                    einx |= r[32];
                end else if (merge_i) begin
                    edst[j*32 +: 32] = prev_i[j*32 +: 32];
                end
            end
        end
        vectors++;
        if (dst_o !== edst || inv_o !== einv || inx_o !== einx) begin
            fails++;
            $display("FAIL %s: dst=%h inv=%b inx=%b expected dst=%h inv=%b inx=%b",
                     tag, dst_o, inv_o, inx_o, edst, einv, einx);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        src_i  = {8{64'h3FF8_0000_0000_0000}};
        prev_i = {8{32'hDEAD_BEEF}};
        nomask_i = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        vectors++;
        if (dst_o !== '0 || inv_o !== 1'b0 || inx_o !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: dst=%h inv=%b inx=%b expected all zero", dst_o, inv_o, inx_o);
        end
        rst_n = 1'b1;

        // R8/R9 rounding sweep: quarter steps through all modes
        for (int m = 0; m < 4; m++) begin
            for (int k = -12; k <= 40; k++) begin
                @(negedge clk);
                vl_i = 2'd0; mem_src_i = 1'b0; bcst_i = 1'b0; nomask_i = 1'b1;
                glob_rm_i = 2'(m);
                src_i = '0;
                src_i[63:0]   = $realtobits(k / 4.0);
                src_i[127:64] = $realtobits(k / 4.0 + 1.0);
                apply_check("R8/R9 rounding");
            end
            for (int k = -3; k <= 6; k++) begin
                @(negedge clk);
                glob_rm_i = 2'(m);
                src_i = '0;
                src_i[63:0] = $realtobits(4294967295.0 + k / 4.0);
                apply_check("R8 range edge");
            end
        end

        // R2/R3/R4/R5/R10 mask sweep
        for (int v = 0; v < 4; v++) begin
            for (int mk = 0; mk < 256; mk++) begin
                for (int c = 0; c < 4; c++) begin
                    @(negedge clk);
                    vl_i = 2'(v); mask_i = 8'(mk);
                    merge_i = c[0]; nomask_i = c[1];
                    mem_src_i = 1'b0; bcst_i = 1'b0; glob_rm_i = 2'(mk % 4);
                    for (int j = 0; j < 8; j++) begin
                        src_i[j*64 +: 64] = pool(mk + 3*j + v);
                        prev_i[j*32 +: 32] = 32'hA500_0000 + 32'(mk * 16 + j);
                    end
                    apply_check("R2/R3/R4/R5/R10 mask");
                end
            end
        end

        // R6/R7 broadcast and rounding selection
        for (int cmb = 0; cmb < 256; cmb++) begin
            @(negedge clk);
            mem_src_i = cmb[0]; bcst_i = cmb[1]; vl_i = cmb[3:2];
            glob_rm_i = cmb[5:4]; emb_rm_i = cmb[7:6];
            mask_i = 8'hFF; nomask_i = 1'b0; merge_i = 1'b0;
            src_i[63:0]    = $realtobits(2.5);
            src_i[127:64]  = $realtobits(-0.4);
            src_i[191:128] = $realtobits(1.5);
            src_i[255:192] = $realtobits(7.75);
            src_i[319:256] = $realtobits(-0.5);
            src_i[383:320] = $realtobits(10.25);
            src_i[447:384] = $realtobits(3.5);
            src_i[511:448] = $realtobits(99.5);
            apply_check("R6/R7 select");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule